// File: doc/BRIEF.md
# CD-ROM decoder register file

This block is the byte-wide register bank of a CD-ROM sector decoder. A host reaches sixteen read locations and sixteen write locations through one 4-bit index. The read map and the write map are different, and the index steps forward by itself after most accesses, so a host can stream through a run of registers with a single index load. The host sets the index with `idx_load`. It then issues `reg_rd` or `reg_wr` pulses. Each read returns its byte one cycle later on `rd_data`, marked by a single-cycle `rd_valid`. The return path has no back-pressure: the host must take the byte in the cycle `rd_valid` is high.

Some accesses have side effects beyond storing a byte:
- A transfer trigger, an acknowledge, an interface-control write and a soft reset act on the transfer state.
- The bank keeps track of which decode registers the host has read since the last decoded block.
- It raises a decode-ready status once the full set has been read.

The header bytes are produced from a block address by a small iterative converter that yields BCD minute, second and frame. The conversion uses 75 frames per second and 60 seconds per minute, with no offset added to the address. The sector buffer and the data mover are outside this block. The mover sees the byte count, the buffer address, a busy level and start/stop pulses, and it reports the end of a transfer on `xfer_end`.

Top module: `cdc_regfile`

## Requirements
- R1: A read returns, by index 0x0..0xF: command-in (always 0x00), interface status, count low, count high, header 0..3, pointer low, pointer high, write address low, write address high, status 0..3. After a read, the index becomes index+1, except that a read at 0xF leaves it at 0xF.
- R2: A write stores, by index 0x0..0xF: sub-byte out (discarded), interface control, count low, count high, buffer address low, buffer address high, trigger, acknowledge, write address low, write address high, control 0, control 1, pointer low, pointer high, control 2 (discarded), soft reset. Writes at 0x6, 0x7, 0xE and 0xF leave the index unchanged; all other writes advance it by one. `idx_load` takes priority over any advance in the same cycle.
- R3: `rd_data` and `rd_valid` appear in the cycle after `reg_rd`. If `reg_rd` and `reg_wr` arrive together, only the write takes place and `rd_valid` stays low.
- R4: After reset: index 0, interface status 0xFF, count 0, buffer address 0, header bytes 00,00,00,01, pointer 0, write address 4704 (0x1260), status bytes 0x80,0,0,0, `xfer_busy` low, `hdr_ready` high.
- R5: Writing interface control with bit 1 clear zeroes the count, drops `xfer_busy`, sets interface-status bit 3 and pulses `xfer_stop` for one cycle.
- R6: Writing the trigger while interface-control bit 1 is set clears interface-status bit 3, raises `xfer_busy` and pulses `xfer_start` for one cycle. The same pulse tells the outside mode register to clear its end-of-transfer bit. With bit 1 clear, the trigger has no effect.
- R7: Writing the acknowledge sets interface-status bit 6.
- R8: An `xfer_end` pulse zeroes the count, drops `xfer_busy` and sets interface-status bit 3. If interface-control bit 6 is set, it also clears interface-status bit 6.
- R9: Reads of indices 1, 4..9 and 12..14 are recorded in a tracking mask. A read at 0xF returns the old status 3 and sets interface-status bit 5. If control-0 bit 7 and interface-control bit 5 are both set and the mask covers 0x73F2, status 3 then becomes 0x80.
- R10: A `dec_event` pulse clears the tracking mask, clears status 3 to 0x00 and clears interface-status bit 5.
- R11: While control-1 bit 0 is set, all four header bytes read as 0x00.
- R12: A `hdr_refresh` pulse converts `blk_addr`. Meanwhile `hdr_ready` is low. When it returns high, headers 0..2 hold BCD minute, second and frame, and header 3 reads 0x01.
- R13: A write at 0xF restores every register to its reset value, except the index, which stays at 0xF. It also starts a header conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_load | input | 1 | Load the register index from idx_val |
| idx_val | input | 4 | New index value |
| reg_rd | input | 1 | Read the register at the current index |
| reg_wr | input | 1 | Write wr_data to the register at the current index |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| cur_idx | output | 4 | Current register index |
| blk_addr | input | LBA_W | Block address for header conversion |
| hdr_refresh | input | 1 | Start a header conversion |
| hdr_ready | output | 1 | High when no conversion is running |
| dec_event | input | 1 | A new block has been decoded |
| xfer_end | input | 1 | Data mover finished the transfer |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_start | output | 1 | One-cycle start pulse; also clears the external end bit |
| xfer_stop | output | 1 | One-cycle stop pulse |
| byte_count | output | 16 | Transfer byte count |
| buf_addr | output | 16 | Transfer buffer address |

## Verification
The bench goes after the index rules first:
- It checks that reads at 0xF do not advance the index, and that the trigger, acknowledge, control-2 and soft-reset writes hold it. A design that advanced there would send the next access to the wrong register, and the scoreboard's later byte comparisons would catch it.

For decode-ready, it runs one complete read set and two incomplete cases:
- In one, the interface-status read is skipped. In the other, the enable bit is clear.
- A design that ignored part of the mask, or the enables, would return 0x80 on the second status-3 read.
- A design that returned the updated value would show 0x80 on the first status-3 read.

For the header converter, it uses addresses at frame 74, at the last frame before a minute rolls over, and exactly on that minute. A BCD carry error would show as a hex digit or a missing minute.

For transfer control, it covers a trigger with the enable clear, stop through interface control, and an end report with and without its interrupt enable. It also checks that a soft reset stops a running transfer while keeping the index at 0xF.

// File: rtl/cdcr_pkg.sv
package cdcr_pkg;

  // Read locations whose access counts toward decode completion.
  localparam logic [15:0] TRACK_SET      = 16'h73F2;
  localparam int          FRAMES_PER_SEC = 75;
  localparam int          SECS_PER_MIN   = 60;

  typedef enum logic [3:0] {
    W_SUBOUT = 4'h0, W_IFCTRL = 4'h1, W_CNT_LO = 4'h2, W_CNT_HI = 4'h3,
    W_ADR_LO = 4'h4, W_ADR_HI = 4'h5, W_TRIG   = 4'h6, W_ACK    = 4'h7,
    W_WA_LO  = 4'h8, W_WA_HI  = 4'h9, W_CTL0   = 4'hA, W_CTL1   = 4'hB,
    W_PT_LO  = 4'hC, W_PT_HI  = 4'hD, W_CTL2   = 4'hE, W_SRST   = 4'hF
  } wr_sel_e;

  typedef enum logic [3:0] {
    R_CMDIN = 4'h0, R_IFSTAT = 4'h1, R_CNT_LO = 4'h2, R_CNT_HI = 4'h3,
    R_HDR0  = 4'h4, R_HDR1   = 4'h5, R_HDR2   = 4'h6, R_HDR3   = 4'h7,
    R_PT_LO = 4'h8, R_PT_HI  = 4'h9, R_WA_LO  = 4'hA, R_WA_HI  = 4'hB,
    R_ST0   = 4'hC, R_ST1    = 4'hD, R_ST2    = 4'hE, R_ST3    = 4'hF
  } rd_sel_e;

  // Two-digit BCD increment, 99 wraps to 00.
  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    logic [3:0] lo, hi;
    lo = b[3:0];
    hi = b[7:4];
    if (lo == 4'd9) begin
      lo = 4'd0;
      hi = (hi == 4'd9) ? 4'd0 : hi + 4'd1;
    end else begin
      lo = lo + 4'd1;
    end
    return {hi, lo};
  endfunction

  // Binary value below 100 to two BCD digits (multiply-shift for tens).
  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [17:0] prod;
    logic [3:0]  tens;
    logic [6:0]  ones;
    prod = {11'd0, v} * 18'd205;
    tens = prod[14:11];
    ones = v - 7'(tens) * 7'd10;
    return {tens, ones[3:0]};
  endfunction

endpackage

// File: rtl/cdcr_msf.sv
module cdcr_msf
  import cdcr_pkg::*;
#(
  parameter int LBA_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LBA_W-1:0] lba,
  output logic             ready,
  output logic [7:0]       min_bcd,
  output logic [7:0]       sec_bcd,
  output logic [7:0]       frm_bcd
);

  localparam logic [LBA_W-1:0] FPS      = LBA_W'(FRAMES_PER_SEC);
  localparam logic [7:0]       SEC_LAST = bin_to_bcd(7'(SECS_PER_MIN - 1));

  logic             busy;
  logic [LBA_W-1:0] rem;
  logic [7:0]       s_acc, m_acc;

  assign ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rem     <= '0;
      s_acc   <= '0;
      m_acc   <= '0;
      min_bcd <= '0;
      sec_bcd <= '0;
      frm_bcd <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      rem   <= lba;
      s_acc <= '0;
      m_acc <= '0;
    end else if (busy) begin
      if (rem >= FPS) begin
        rem <= rem - FPS;
        if (s_acc == SEC_LAST) begin
          s_acc <= '0;
          m_acc <= bcd_inc(m_acc);
        end else begin
          s_acc <= bcd_inc(s_acc);
        end
      end else begin
        busy    <= 1'b0;
        min_bcd <= m_acc;
        sec_bcd <= s_acc;
        frm_bcd <= bin_to_bcd(rem[6:0]);
      end
    end
  end

endmodule

// File: rtl/cdcr_xfer.sv
module cdcr_xfer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sreset,
  input  logic        wr_ifctrl,
  input  logic        wr_cnt_lo,
  input  logic        wr_cnt_hi,
  input  logic        wr_adr_lo,
  input  logic        wr_adr_hi,
  input  logic        wr_trig,
  input  logic        wr_ack,
  input  logic [7:0]  wdata,
  input  logic        xfer_end,
  output logic        ifc_en,
  output logic        ifc_dte_ie,
  output logic        ifc_dec_ie,
  output logic [15:0] count,
  output logic [15:0] addr,
  output logic        busy,
  output logic        dte_n,
  output logic        start_pls,
  output logic        stop_pls
);

  always_ff @(posedge clk) begin
    if (!rst_n || sreset) begin
      ifc_en     <= 1'b0;
      ifc_dte_ie <= 1'b0;
      ifc_dec_ie <= 1'b0;
      count      <= '0;
      addr       <= '0;
      busy       <= 1'b0;
      dte_n      <= 1'b1;
      start_pls  <= 1'b0;
      stop_pls   <= 1'b0;
    end else begin
      start_pls <= 1'b0;
      stop_pls  <= 1'b0;
      if (xfer_end) begin
        count <= '0;
        busy  <= 1'b0;
        if (ifc_dte_ie) dte_n <= 1'b0;
      end
      if (wr_cnt_lo) count[7:0]  <= wdata;
      if (wr_cnt_hi) count[15:8] <= wdata;
      if (wr_adr_lo) addr[7:0]   <= wdata;
      if (wr_adr_hi) addr[15:8]  <= wdata;
      if (wr_ifctrl) begin
        ifc_en     <= wdata[1];
        ifc_dec_ie <= wdata[5];
        ifc_dte_ie <= wdata[6];
        if (!wdata[1]) begin
          count    <= '0;
          busy     <= 1'b0;
          stop_pls <= 1'b1;
        end
      end
      if (wr_trig && ifc_en) begin
        busy      <= 1'b1;
        start_pls <= 1'b1;
      end
      if (wr_ack) dte_n <= 1'b1;
    end
  end

endmodule

// File: rtl/cdcr_track.sv
module cdcr_track
  import cdcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sreset,
  input  logic       rd_fire,
  input  logic [3:0] rd_idx,
  input  logic       dec_event,
  input  logic       ifc_dec_ie,
  input  logic       ctl_dec_en,
  output logic [7:0] stat3,
  output logic       dec_n
);

  logic [15:0] seen;
  logic [15:0] hit;

  assign hit = (16'd1 << rd_idx) & TRACK_SET;

  always_ff @(posedge clk) begin
    if (!rst_n || sreset) begin
      seen  <= '0;
      stat3 <= '0;
      dec_n <= 1'b1;
    end else if (dec_event) begin
      seen  <= '0;
      stat3 <= '0;
      dec_n <= 1'b0;
    end else if (rd_fire) begin
      seen <= seen | hit;
      if (rd_idx == R_ST3) begin
        dec_n <= 1'b1;
        if (ctl_dec_en && ifc_dec_ie && ((seen & TRACK_SET) == TRACK_SET))
          stat3 <= 8'h80;
      end
    end
  end

endmodule

// File: rtl/cdc_regfile.sv
module cdc_regfile
  import cdcr_pkg::*;
#(
  parameter int          LBA_W    = 17,
  parameter logic [15:0] WA_RESET = 16'd4704
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic [3:0]       idx_val,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic [3:0]       cur_idx,
  input  logic [LBA_W-1:0] blk_addr,
  input  logic             hdr_refresh,
  output logic             hdr_ready,
  input  logic             dec_event,
  input  logic             xfer_end,
  output logic             xfer_busy,
  output logic             xfer_start,
  output logic             xfer_stop,
  output logic [15:0]      byte_count,
  output logic [15:0]      buf_addr
);

  localparam logic [7:0] ST0_RESET = 8'h80;
  localparam logic [7:0] HDR3_MARK = 8'h01;

  logic [3:0]  idx_q;
  logic        wr_fire, rd_fire, sreset;
  wr_sel_e     wsel;
  rd_sel_e     rsel;
  logic [15:0] wa_q, pt_q;
  logic        ctl_dec_en, ctl_hdr_off;
  logic        ifc_en, ifc_dte_ie, ifc_dec_ie, dte_n, dec_n;
  logic [7:0]  stat3, ifstat, rd_mux;
  logic [7:0]  m_bcd, s_bcd, f_bcd;
  logic [7:0]  hdr0, hdr1, hdr2, hdr3;
  logic        idx_holds_wr;

  assign wr_fire = reg_wr;
  assign rd_fire = reg_rd && !reg_wr;
  assign wsel    = wr_sel_e'(idx_q);
  assign rsel    = rd_sel_e'(idx_q);
  assign sreset  = wr_fire && (wsel == W_SRST);
  assign cur_idx = idx_q;

  assign idx_holds_wr = (wsel == W_TRIG) || (wsel == W_ACK) ||
                        (wsel == W_CTL2) || (wsel == W_SRST);

  // Index sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_load) begin
      idx_q <= idx_val;
    end else if (wr_fire) begin
      if (!idx_holds_wr) idx_q <= idx_q + 4'd1;
    end else if (rd_fire) begin
      if (rsel != R_ST3) idx_q <= idx_q + 4'd1;
    end
  end

  // Plain storage registers
  always_ff @(posedge clk) begin
    if (!rst_n || sreset) begin
      wa_q        <= WA_RESET;
      pt_q        <= '0;
      ctl_dec_en  <= 1'b0;
      ctl_hdr_off <= 1'b0;
    end else if (wr_fire) begin
      case (wsel)
        W_WA_LO: wa_q[7:0]   <= wr_data;
        W_WA_HI: wa_q[15:8]  <= wr_data;
        W_PT_LO: pt_q[7:0]   <= wr_data;
        W_PT_HI: pt_q[15:8]  <= wr_data;
        W_CTL0:  ctl_dec_en  <= wr_data[7];
        W_CTL1:  ctl_hdr_off <= wr_data[0];
        default: ;
      endcase
    end
  end

  cdcr_xfer u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sreset     (sreset),
    .wr_ifctrl  (wr_fire && wsel == W_IFCTRL),
    .wr_cnt_lo  (wr_fire && wsel == W_CNT_LO),
    .wr_cnt_hi  (wr_fire && wsel == W_CNT_HI),
    .wr_adr_lo  (wr_fire && wsel == W_ADR_LO),
    .wr_adr_hi  (wr_fire && wsel == W_ADR_HI),
    .wr_trig    (wr_fire && wsel == W_TRIG),
    .wr_ack     (wr_fire && wsel == W_ACK),
    .wdata      (wr_data),
    .xfer_end   (xfer_end),
    .ifc_en     (ifc_en),
    .ifc_dte_ie (ifc_dte_ie),
    .ifc_dec_ie (ifc_dec_ie),
    .count      (byte_count),
    .addr       (buf_addr),
    .busy       (xfer_busy),
    .dte_n      (dte_n),
    .start_pls  (xfer_start),
    .stop_pls   (xfer_stop)
  );

  cdcr_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .sreset     (sreset),
    .rd_fire    (rd_fire),
    .rd_idx     (idx_q),
    .dec_event  (dec_event),
    .ifc_dec_ie (ifc_dec_ie),
    .ctl_dec_en (ctl_dec_en),
    .stat3      (stat3),
    .dec_n      (dec_n)
  );

  cdcr_msf #(.LBA_W(LBA_W)) u_msf (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (hdr_refresh || sreset),
    .lba     (blk_addr),
    .ready   (hdr_ready),
    .min_bcd (m_bcd),
    .sec_bcd (s_bcd),
    .frm_bcd (f_bcd)
  );

  assign ifstat = {1'b1, dte_n, dec_n, 1'b1, !xfer_busy, 3'b111};

  assign hdr0 = ctl_hdr_off ? 8'h00 : m_bcd;
  assign hdr1 = ctl_hdr_off ? 8'h00 : s_bcd;
  assign hdr2 = ctl_hdr_off ? 8'h00 : f_bcd;
  assign hdr3 = ctl_hdr_off ? 8'h00 : HDR3_MARK;

  always_comb begin
    case (rsel)
      R_CMDIN:  rd_mux = 8'h00;
      R_IFSTAT: rd_mux = ifstat;
      R_CNT_LO: rd_mux = byte_count[7:0];
      R_CNT_HI: rd_mux = byte_count[15:8];
      R_HDR0:   rd_mux = hdr0;
      R_HDR1:   rd_mux = hdr1;
      R_HDR2:   rd_mux = hdr2;
      R_HDR3:   rd_mux = hdr3;
      R_PT_LO:  rd_mux = pt_q[7:0];
      R_PT_HI:  rd_mux = pt_q[15:8];
      R_WA_LO:  rd_mux = wa_q[7:0];
      R_WA_HI:  rd_mux = wa_q[15:8];
      R_ST0:    rd_mux = ST0_RESET;
      R_ST1:    rd_mux = 8'h00;
      R_ST2:    rd_mux = 8'h00;
      default:  rd_mux = stat3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/cdcr_checks.sv
module cdcr_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        idx_load,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic [7:0]  wr_data,
  input logic [3:0]  cur_idx,
  input logic        rd_valid,
  input logic        xfer_busy,
  input logic        xfer_start,
  input logic        xfer_stop,
  input logic [15:0] byte_count,
  input logic        ifc_en
);

  a_r1_last_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && !idx_load && cur_idx == 4'hF) |=> cur_idx == 4'hF);

  a_r1_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && !idx_load && cur_idx != 4'hF)
      |=> cur_idx == $past(cur_idx) + 4'd1);

  a_r2_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !idx_load && (cur_idx == 4'h6 || cur_idx == 4'h7 ||
     cur_idx == 4'hE || cur_idx == 4'hF)) |=> $stable(cur_idx));

  a_r3_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> rd_valid);

  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !rd_valid);

  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && cur_idx == 4'h1 && !wr_data[1])
      |=> (!xfer_busy && byte_count == 16'd0 && xfer_stop));

  a_r5_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stop |-> !xfer_busy);

  a_r6_trigger_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && cur_idx == 4'h6 && ifc_en) |=> (xfer_busy && xfer_start));

  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> xfer_busy);

endmodule

bind cdc_regfile cdcr_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idx_load   (idx_load),
  .reg_rd     (reg_rd),
  .reg_wr     (reg_wr),
  .wr_data    (wr_data),
  .cur_idx    (cur_idx),
  .rd_valid   (rd_valid),
  .xfer_busy  (xfer_busy),
  .xfer_start (xfer_start),
  .xfer_stop  (xfer_stop),
  .byte_count (byte_count),
  .ifc_en     (ifc_en)
);

// File: tb/cdc_regfile_test.sv
`timescale 1ns/1ps
module cdc_regfile_test;

  localparam int LBA_W = 17;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             idx_load = 1'b0;
  logic [3:0]       idx_val = '0;
  logic             reg_rd = 1'b0;
  logic             reg_wr = 1'b0;
  logic [7:0]       wr_data = '0;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic [3:0]       cur_idx;
  logic [LBA_W-1:0] blk_addr = '0;
  logic             hdr_refresh = 1'b0;
  logic             hdr_ready;
  logic             dec_event = 1'b0;
  logic             xfer_end = 1'b0;
  logic             xfer_busy, xfer_start, xfer_stop;
  logic [15:0]      byte_count, buf_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cdc_regfile #(.LBA_W(LBA_W)) uut (
    .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .idx_val(idx_val),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .cur_idx(cur_idx), .blk_addr(blk_addr),
    .hdr_refresh(hdr_refresh), .hdr_ready(hdr_ready), .dec_event(dec_event),
    .xfer_end(xfer_end), .xfer_busy(xfer_busy), .xfer_start(xfer_start),
    .xfer_stop(xfer_stop), .byte_count(byte_count), .buf_addr(buf_addr)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every read strobe pops one expected byte.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3: actual unexpected read %h expected none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic load_idx(input logic [3:0] i);
    @(negedge clk); idx_load = 1'b1; idx_val = i;
    @(negedge clk); idx_load = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; wr_data = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic wait_hdr();
    for (int n = 0; n < 20000 && !hdr_ready; n++) @(negedge clk);
  endtask

  task automatic convert(input int lba, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] f);
    blk_addr = LBA_W'(lba);
    pulse(hdr_refresh);
    chk({15'd0, hdr_ready}, 16'd0, "R12 converting");
    wait_hdr();
    load_idx(4'h4);
    rd_byte(m, "R12 minute");
    rd_byte(s, "R12 second");
    rd_byte(f, "R12 frame");
    rd_byte(8'h01, "R12 marker");
  endtask

  task automatic read_tracked_set(input logic skip_ifstat);
    if (!skip_ifstat) begin
      load_idx(4'h1);
      rd_byte(8'hDF, "R10 ifstat bit5 clear");
    end
    load_idx(4'h4);
    rd_byte(8'h01, "R9 hdr0"); rd_byte(8'h00, "R9 hdr1");
    rd_byte(8'h00, "R9 hdr2"); rd_byte(8'h01, "R9 hdr3");
    rd_byte(8'h44, "R9 ptl");  rd_byte(8'h33, "R9 pth");
    load_idx(4'hC);
    rd_byte(8'h80, "R9 st0"); rd_byte(8'h00, "R9 st1"); rd_byte(8'h00, "R9 st2");
  endtask

  task automatic read_reset_map(input string tag);
    rd_byte(8'h00, tag); rd_byte(8'hFF, tag); rd_byte(8'h00, tag); rd_byte(8'h00, tag);
    rd_byte(8'h00, tag); rd_byte(8'h00, tag); rd_byte(8'h00, tag); rd_byte(8'h01, tag);
    rd_byte(8'h00, tag); rd_byte(8'h00, tag); rd_byte(8'h60, tag); rd_byte(8'h12, tag);
    rd_byte(8'h80, tag); rd_byte(8'h00, tag); rd_byte(8'h00, tag); rd_byte(8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state, R1 full read map with auto-increment
    chk({12'd0, cur_idx}, 16'h0, "R4 index");
    chk({15'd0, xfer_busy}, 16'h0, "R4 busy");
    chk(byte_count, 16'h0, "R4 count");
    chk(buf_addr, 16'h0, "R4 address");
    chk({15'd0, hdr_ready}, 16'h1, "R4 hdr_ready");
    read_reset_map("R4 R1 reset read map");
    chk({12'd0, cur_idx}, 16'hF, "R1 index holds at F");
    rd_byte(8'h00, "R1 second read at F");
    chk({12'd0, cur_idx}, 16'hF, "R1 index still F");

    // R2 write map, R6 trigger
    load_idx(4'h0);
    wr_byte(8'h99); wr_byte(8'h02); wr_byte(8'h34); wr_byte(8'h12);
    wr_byte(8'h78); wr_byte(8'h56);
    chk({12'd0, cur_idx}, 16'h6, "R2 index after six writes");
    chk(byte_count, 16'h1234, "R2 count");
    chk(buf_addr, 16'h5678, "R2 address");
    wr_byte(8'h00);
    chk({15'd0, xfer_start}, 16'h1, "R6 start pulse");
    chk({15'd0, xfer_busy}, 16'h1, "R6 busy");
    chk({12'd0, cur_idx}, 16'h6, "R2 trigger holds index");
    @(negedge clk);
    chk({15'd0, xfer_start}, 16'h0, "R6 start is one cycle");
    load_idx(4'h1);
    rd_byte(8'hF7, "R6 ifstat bit3 clear");
    rd_byte(8'h34, "R1 count low");
    rd_byte(8'h12, "R1 count high");

    // R8 end of transfer with interrupt enable, R7 acknowledge
    load_idx(4'h1);
    wr_byte(8'h42);
    chk({15'd0, xfer_busy}, 16'h1, "R5 bit1 set keeps busy");
    pulse(xfer_end);
    chk({15'd0, xfer_busy}, 16'h0, "R8 busy dropped");
    chk(byte_count, 16'h0, "R8 count zeroed");
    load_idx(4'h1);
    rd_byte(8'hBF, "R8 ifstat bit6 clear bit3 set");
    load_idx(4'h7);
    wr_byte(8'h00);
    chk({12'd0, cur_idx}, 16'h7, "R2 ack holds index");
    load_idx(4'h1);
    rd_byte(8'hFF, "R7 ifstat bit6 set");

    // R8 end without interrupt enable leaves bit6 set
    load_idx(4'h1);
    wr_byte(8'h02);
    load_idx(4'h6);
    wr_byte(8'h00);
    pulse(xfer_end);
    load_idx(4'h1);
    rd_byte(8'hFF, "R8 bit6 kept without enable");

    // R5 stop through interface control
    load_idx(4'h1);
    wr_byte(8'h02); wr_byte(8'h10); wr_byte(8'h00);
    load_idx(4'h6);
    wr_byte(8'h00);
    chk(byte_count, 16'h0010, "R6 count loaded");
    chk({15'd0, xfer_busy}, 16'h1, "R6 busy again");
    load_idx(4'h1);
    wr_byte(8'h00);
    chk({15'd0, xfer_stop}, 16'h1, "R5 stop pulse");
    chk({15'd0, xfer_busy}, 16'h0, "R5 busy dropped");
    chk(byte_count, 16'h0, "R5 count zeroed");
    load_idx(4'h1);
    rd_byte(8'hFF, "R5 ifstat bit3 set");
    load_idx(4'h6);
    wr_byte(8'h00);
    chk({15'd0, xfer_start}, 16'h0, "R6 no start when disabled");
    chk({15'd0, xfer_busy}, 16'h0, "R6 no busy when disabled");
    load_idx(4'h1);
    rd_byte(8'hFF, "R6 ifstat unchanged when disabled");

    // R2 upper write map, R11 header masking
    load_idx(4'h8);
    wr_byte(8'h22); wr_byte(8'h11); wr_byte(8'h80); wr_byte(8'h01);
    wr_byte(8'h44); wr_byte(8'h33); wr_byte(8'h5A);
    chk({12'd0, cur_idx}, 16'hE, "R2 control-2 holds index");
    load_idx(4'h4);
    rd_byte(8'h00, "R11 hdr0"); rd_byte(8'h00, "R11 hdr1");
    rd_byte(8'h00, "R11 hdr2"); rd_byte(8'h00, "R11 hdr3");
    rd_byte(8'h44, "R2 pointer low"); rd_byte(8'h33, "R2 pointer high");
    rd_byte(8'h22, "R2 write addr low"); rd_byte(8'h11, "R2 write addr high");

    // R12 header conversion
    load_idx(4'hB);
    wr_byte(8'h00);
    convert(10017, 8'h02, 8'h13, 8'h42);
    convert(74,    8'h00, 8'h00, 8'h74);
    convert(4499,  8'h00, 8'h59, 8'h74);
    convert(4500,  8'h01, 8'h00, 8'h00);

    // R9 full tracked set with both enables, R10 clears
    pulse(dec_event);
    load_idx(4'h1);
    wr_byte(8'h20);
    read_tracked_set(1'b0);
    rd_byte(8'h00, "R9 returns old status 3");
    rd_byte(8'h80, "R9 decode ready");
    load_idx(4'h1);
    rd_byte(8'hFF, "R9 ifstat bit5 set");

    // R9 missing interface-status read
    pulse(dec_event);
    read_tracked_set(1'b1);
    rd_byte(8'h00, "R10 status 3 cleared");
    rd_byte(8'h00, "R9 incomplete set");

    // R9 decode enable in interface control clear
    pulse(dec_event);
    load_idx(4'h1);
    wr_byte(8'h00);
    read_tracked_set(1'b0);
    rd_byte(8'h00, "R9 disabled first");
    rd_byte(8'h00, "R9 disabled second");

    // R13 soft reset during a transfer
    blk_addr = '0;
    load_idx(4'h1);
    wr_byte(8'h02); wr_byte(8'h08); wr_byte(8'h00);
    load_idx(4'h6);
    wr_byte(8'h00);
    chk({15'd0, xfer_busy}, 16'h1, "R13 busy before soft reset");
    load_idx(4'hF);
    wr_byte(8'hAA);
    chk({12'd0, cur_idx}, 16'hF, "R13 index kept");
    chk({15'd0, xfer_busy}, 16'h0, "R13 busy cleared");
    chk(byte_count, 16'h0, "R13 count cleared");
    chk(buf_addr, 16'h0, "R13 address cleared");
    wait_hdr();
    load_idx(4'h0);
    read_reset_map("R13 reset map after soft reset");

    // R3 read and write together: write only
    load_idx(4'h2);
    @(negedge clk); reg_rd = 1'b1; reg_wr = 1'b1; wr_data = 8'h5A;
    @(negedge clk); reg_rd = 1'b0; reg_wr = 1'b0;
    chk({15'd0, rd_valid}, 16'h0, "R3 no read strobe on collision");
    chk(byte_count, 16'h005A, "R3 write took place");
    chk({12'd0, cur_idx}, 16'h3, "R3 index advanced once");

    repeat (3) @(negedge clk);
    chk(16'(exp_q.size()), 16'h0, "R3 all reads returned");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule